// File: doc/BRIEF.md
# Load-Store Memory Scheduler

This block sits between address generation and the data memory of an out-of-order core. It keeps one record per instruction-queue slot that holds a memory instruction. A record is opened when the slot is filled, and it receives its target address (and, for a store, its write data) when execute computes it. Each cycle the block looks for records that are ready to go to memory. It picks the oldest one, counting age around the ring from the commit head, and offers it on a single request port.

A load may leave as soon as no older record could alias it. That means no older record still lacks an address, and no older store has the same address. A store obeys the same rule, and it also waits until the commit head points at its own slot, so that it only reaches memory once it is certain to commit. A record is released on the cycle its request is accepted.

A store is reported done one cycle after acceptance, so it can commit at once. A load's slot moves through a fixed three-stage tag pipeline. The memory drives the read data during the third cycle after acceptance, and the block presents the slot, the data and the done strobe in the fourth cycle.

The request port is a valid/ready stream. `mreq_valid` is high whenever some record is eligible. A request is accepted only on a cycle where `mreq_valid` and `mreq_ready` are both high. While `mreq_ready` is low nothing leaves and no record is released. The offered request may switch to an older record that becomes eligible before acceptance. The read-data input and the done outputs use fixed timing and have no back-pressure. The slot count must be a power of two.

Top module: `mem_dispatch_sched`

## Requirements
- R1: After reset no record is live: `mreq_valid`, `wb_valid` and `st_done_valid` are low.
- R2: In the cycle after a load record receives its address, with nothing older pending, the block offers it: `mreq_valid`=1, `mreq_tag`=slot, `mreq_addr`=the latched address, `mreq_is_store`=0 (0 = load, 1 = store).
- R3: A record is not offered while any older live record still has no address.
- R4: A load is not offered while an older live store has the same address. An older store with a different address does not hold it back.
- R5: Two loads accepted on consecutive cycles return on consecutive cycles, each with its own slot and the data present during its own read cycle.
- R6: A store is offered only while `head_ptr` equals its slot, together with its address and write data.
- R7: Among eligible records the one nearest the head wins, with age taken as (slot - `head_ptr`) modulo the slot count.
- R8: While `mreq_ready` is low the offer stays valid, and no record is dispatched or released.
- R9: A load accepted on the rising edge that ends cycle T raises `wb_valid` for exactly one cycle, in cycle T+4. It carries its slot and the `mem_rdata` value driven during cycle T+3.
- R10: A store accepted on the rising edge that ends cycle T raises `st_done_valid` with its slot for exactly one cycle, in cycle T+1.
- R11: An accepted record is released, and it is not offered again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Open a record for a newly queued memory instruction |
| enq_slot | input | IW | Queue slot of the new record |
| enq_is_store | input | 1 | 1 = store, 0 = load |
| agen_valid | input | 1 | Address from execute is present |
| agen_slot | input | IW | Slot whose address is being latched |
| agen_addr | input | AW | Computed target address |
| agen_wdata | input | DW | Store data (ignored for loads) |
| head_ptr | input | IW | Commit head slot |
| mreq_valid | output | 1 | A memory request is offered |
| mreq_ready | input | 1 | Memory queue accepts the offer |
| mreq_is_store | output | 1 | Kind of offered request |
| mreq_tag | output | IW | Slot of offered request |
| mreq_addr | output | AW | Address of offered request |
| mreq_wdata | output | DW | Write data of offered store |
| mem_rdata | input | DW | Read data, driven in the third cycle after a load is accepted |
| wb_valid | output | 1 | Load result and done strobe |
| wb_slot | output | IW | Slot of the finished load |
| wb_data | output | DW | Loaded value |
| st_done_valid | output | 1 | Store done strobe |
| st_done_slot | output | IW | Slot of the finished store |

## Verification
The bench sets up the cases where an age comparison or an alias check could go wrong.

- It wraps the head past the end of the ring. An index-ordered picker would then dispatch the wrong load.
- It places an older store that is not at the head ahead of a load with the same address and a load with a different address. A loose alias check would let the aliasing load through, and an over-strict one would also stall the unrelated load.
- It moves the head onto the store to show that the store goes out only at that point and is reported done on the following cycle.
- It accepts two loads back to back and feeds their data one cycle apart. An off-by-one tag pipeline would latch the wrong word or pair it with the wrong slot.
- It holds `mreq_ready` low to catch a design that drops or releases a request that was never accepted.

// File: rtl/msched_pkg.sv
package msched_pkg;
  typedef enum logic {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } mem_kind_e;
endpackage

// File: rtl/msched_table.sv
// Per-slot record storage: open, address latch, release.
module msched_table
  import msched_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq_valid,
  input  logic [IW-1:0]        enq_slot,
  input  logic                 enq_is_store,
  input  logic                 agen_valid,
  input  logic [IW-1:0]        agen_slot,
  input  logic [AW-1:0]        agen_addr,
  input  logic [DW-1:0]        agen_wdata,
  input  logic                 clr_valid,
  input  logic [IW-1:0]        clr_slot,
  output logic [N-1:0]         ent_vld,
  output logic [N-1:0]         ent_st,
  output logic [N-1:0]         ent_gen,
  output logic [N-1:0][AW-1:0] ent_addr,
  output logic [N-1:0][DW-1:0] ent_wdata
);
  for (genvar g = 0; g < N; g++) begin : g_rec
    mem_kind_e kind_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[g]   <= 1'b0;
        ent_gen[g]   <= 1'b0;
        kind_q       <= KIND_LOAD;
        ent_addr[g]  <= '0;
        ent_wdata[g] <= '0;
      end else begin
        if (clr_valid && clr_slot == IW'(g)) begin
          ent_vld[g] <= 1'b0;
          ent_gen[g] <= 1'b0;
        end
        if (enq_valid && enq_slot == IW'(g)) begin
          ent_vld[g] <= 1'b1;
          ent_gen[g] <= 1'b0;
          kind_q     <= enq_is_store ? KIND_STORE : KIND_LOAD;
        end
        if (agen_valid && agen_slot == IW'(g)) begin
          ent_gen[g]   <= 1'b1;
          ent_addr[g]  <= agen_addr;
          ent_wdata[g] <= agen_wdata;
        end
      end
    end
    assign ent_st[g] = (kind_q == KIND_STORE);
  end
endmodule

// File: rtl/msched_hazard.sv
// Alias check against older records and eligibility per slot.
module msched_hazard #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int AW = 32
) (
  input  logic [IW-1:0]        head_ptr,
  input  logic [N-1:0]         ent_vld,
  input  logic [N-1:0]         ent_st,
  input  logic [N-1:0]         ent_gen,
  input  logic [N-1:0][AW-1:0] ent_addr,
  output logic [N-1:0]         elig
);
  logic [N-1:0][IW-1:0] age;
  logic [N-1:0]         blocked;

  for (genvar g = 0; g < N; g++) begin : g_age
    assign age[g] = IW'(g) - head_ptr;
  end

  for (genvar j = 0; j < N; j++) begin : g_chk
    always_comb begin
      blocked[j] = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (i != j && ent_vld[i] && (age[i] < age[j])) begin
          if (!ent_gen[i] || (ent_st[i] && ent_addr[i] == ent_addr[j]))
            blocked[j] = 1'b1;
        end
      end
    end
    assign elig[j] = ent_vld[j] && ent_gen[j] && !blocked[j] &&
                     (!ent_st[j] || head_ptr == IW'(j));
  end
endmodule

// File: rtl/msched_pick.sv
// Oldest-first selection, scanning from the commit head.
module msched_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [IW-1:0] head_ptr,
  input  logic [N-1:0]  elig,
  output logic          any,
  output logic [IW-1:0] sel
);
  logic [N-1:0][IW-1:0] ring_idx;
  for (genvar k = 0; k < N; k++) begin : g_idx
    assign ring_idx[k] = head_ptr + IW'(k);
  end

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (elig[ring_idx[k]]) begin
        any = 1'b1;
        sel = ring_idx[k];
      end
    end
  end
endmodule

// File: rtl/msched_ret.sv
// Fixed-latency load tag pipeline and result latch.
module msched_ret #(
  parameter int IW  = 3,
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_fire,
  input  logic [IW-1:0] ld_tag,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_valid,
  output logic [IW-1:0] wb_slot,
  output logic [DW-1:0] wb_data
);
  logic [LAT-1:0]         v_q;
  logic [LAT-1:0][IW-1:0] t_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q[0] <= 1'b0;
      t_q[0] <= '0;
    end else begin
      v_q[0] <= ld_fire;
      t_q[0] <= ld_tag;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        t_q[s] <= '0;
      end else begin
        v_q[s] <= v_q[s-1];
        t_q[s] <= t_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_slot  <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= v_q[LAT-1];
      if (v_q[LAT-1]) begin
        wb_slot <= t_q[LAT-1];
        wb_data <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/mem_dispatch_sched.sv
module mem_dispatch_sched #(
  parameter int N   = 8,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int LAT = 3,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic [IW-1:0] enq_slot,
  input  logic          enq_is_store,
  input  logic          agen_valid,
  input  logic [IW-1:0] agen_slot,
  input  logic [AW-1:0] agen_addr,
  input  logic [DW-1:0] agen_wdata,
  input  logic [IW-1:0] head_ptr,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic          mreq_is_store,
  output logic [IW-1:0] mreq_tag,
  output logic [AW-1:0] mreq_addr,
  output logic [DW-1:0] mreq_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          wb_valid,
  output logic [IW-1:0] wb_slot,
  output logic [DW-1:0] wb_data,
  output logic          st_done_valid,
  output logic [IW-1:0] st_done_slot
);
  logic [N-1:0]         ent_vld, ent_st, ent_gen, elig;
  logic [N-1:0][AW-1:0] ent_addr;
  logic [N-1:0][DW-1:0] ent_wdata;
  logic                 pick_any;
  logic [IW-1:0]        pick_sel;
  logic                 fire;

  msched_table #(.N(N), .IW(IW), .AW(AW), .DW(DW)) table_i (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_slot(enq_slot), .enq_is_store(enq_is_store),
    .agen_valid(agen_valid), .agen_slot(agen_slot),
    .agen_addr(agen_addr), .agen_wdata(agen_wdata),
    .clr_valid(fire), .clr_slot(pick_sel),
    .ent_vld(ent_vld), .ent_st(ent_st), .ent_gen(ent_gen),
    .ent_addr(ent_addr), .ent_wdata(ent_wdata)
  );

  msched_hazard #(.N(N), .IW(IW), .AW(AW)) hazard_i (
    .head_ptr(head_ptr), .ent_vld(ent_vld), .ent_st(ent_st),
    .ent_gen(ent_gen), .ent_addr(ent_addr), .elig(elig)
  );

  msched_pick #(.N(N), .IW(IW)) pick_i (
    .head_ptr(head_ptr), .elig(elig), .any(pick_any), .sel(pick_sel)
  );

  assign mreq_valid    = pick_any;
  assign mreq_tag      = pick_sel;
  assign mreq_is_store = ent_st[pick_sel];
  assign mreq_addr     = ent_addr[pick_sel];
  assign mreq_wdata    = ent_wdata[pick_sel];
  assign fire          = pick_any && mreq_ready;

  msched_ret #(.IW(IW), .DW(DW), .LAT(LAT)) ret_i (
    .clk(clk), .rst_n(rst_n),
    .ld_fire(fire && !ent_st[pick_sel]), .ld_tag(pick_sel),
    .mem_rdata(mem_rdata),
    .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_data(wb_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_done_valid <= 1'b0;
      st_done_slot  <= '0;
    end else begin
      st_done_valid <= fire && ent_st[pick_sel];
      if (fire && ent_st[pick_sel]) st_done_slot <= pick_sel;
    end
  end
endmodule

// File: rtl/msched_chk.sv
module msched_chk #(
  parameter int IW = 3,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [IW-1:0] head_ptr,
  input logic          mreq_valid,
  input logic          mreq_ready,
  input logic          mreq_is_store,
  input logic [IW-1:0] mreq_tag,
  input logic [DW-1:0] mem_rdata,
  input logic          wb_valid,
  input logic [IW-1:0] wb_slot,
  input logic [DW-1:0] wb_data,
  input logic          st_done_valid,
  input logic [IW-1:0] st_done_slot
);
  logic       fire;
  logic [2:0] since_rst;
  assign fire = mreq_valid && mreq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assert_store_at_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_is_store) |-> (mreq_tag == head_ptr));

  assert_offer_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> mreq_valid);

  assert_load_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && since_rst >= 3'd5) |->
      ($past(fire && !mreq_is_store, 4) && wb_slot == $past(mreq_tag, 4) &&
       wb_data == $past(mem_rdata, 1)));

  assert_store_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done_valid && since_rst >= 3'd2) |->
      ($past(fire && mreq_is_store) && st_done_slot == $past(mreq_tag)));

  assert_no_reoffer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !(mreq_valid && mreq_tag == $past(mreq_tag)));
endmodule

bind mem_dispatch_sched msched_chk #(.IW(IW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .head_ptr(head_ptr),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready),
  .mreq_is_store(mreq_is_store), .mreq_tag(mreq_tag),
  .mem_rdata(mem_rdata), .wb_valid(wb_valid), .wb_slot(wb_slot),
  .wb_data(wb_data), .st_done_valid(st_done_valid),
  .st_done_slot(st_done_slot)
);

// File: tb/mem_dispatch_sched_tb.sv
module mem_dispatch_sched_tb_top;
  localparam int N = 8, AW = 32, DW = 32, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 0, enq_is_store = 0, agen_valid = 0, mreq_ready = 0;
  logic [IW-1:0] enq_slot = '0, agen_slot = '0, head_ptr = '0;
  logic [AW-1:0] agen_addr = '0;
  logic [DW-1:0] agen_wdata = '0, mem_rdata = '0;
  logic mreq_valid, mreq_is_store, wb_valid, st_done_valid;
  logic [IW-1:0] mreq_tag, wb_slot, st_done_slot;
  logic [AW-1:0] mreq_addr;
  logic [DW-1:0] mreq_wdata, wb_data;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mem_dispatch_sched #(.N(N), .AW(AW), .DW(DW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic enq(input int slot, input bit st);
    enq_valid = 1; enq_slot = IW'(slot); enq_is_store = st;
    tick(); enq_valid = 0;
  endtask

  task automatic agen(input int slot, input logic [AW-1:0] a, input logic [DW-1:0] d);
    agen_valid = 1; agen_slot = IW'(slot); agen_addr = a; agen_wdata = d;
    tick(); agen_valid = 0;
  endtask

  task automatic accept_one();
    mreq_ready = 1; tick(); mreq_ready = 0;
  endtask

  task automatic drain();
    mreq_ready = 1; repeat (4) tick(); mreq_ready = 0; repeat (6) tick();
  endtask

  task automatic t_reset();
    chk(!mreq_valid && !wb_valid && !st_done_valid, "R1 quiet after reset",
        {mreq_valid, wb_valid, st_done_valid}, 0);
  endtask

  task automatic t_single_load();
    head_ptr = 0;
    enq(0, 0); agen(0, 32'hA000_0010, 0);
    chk(mreq_valid && mreq_tag == 0 && mreq_addr == 32'hA000_0010 && !mreq_is_store,
        "R2 load offer", {mreq_valid, mreq_is_store, 29'd0, mreq_tag, mreq_addr}, {2'b10, 29'd0, 3'd0, 32'hA000_0010});
    tick();
    chk(mreq_valid && mreq_tag == 0, "R8 offer held while not ready", mreq_valid, 1);
    accept_one();                      // n1
    chk(!mreq_valid, "R11 no re-offer", mreq_valid, 0);
    chk(!wb_valid, "R9 no early result", wb_valid, 0);
    tick();                            // n2
    tick();                            // n3
    chk(!wb_valid, "R9 no early result", wb_valid, 0);
    mem_rdata = 32'h1234_5678;
    tick();                            // n4
    mem_rdata = 32'hDEAD_BEEF;
    chk(wb_valid && wb_slot == 0 && wb_data == 32'h1234_5678, "R9 load result",
        {wb_valid, 28'd0, wb_slot, wb_data}, {1'b1, 28'd0, 3'd0, 32'h1234_5678});
    tick();
    chk(!wb_valid, "R9 single pulse", wb_valid, 0);
  endtask

  task automatic t_no_addr_blocks();
    head_ptr = 0;
    enq(4, 0); enq(5, 0); agen(5, 32'h50, 0);
    chk(!mreq_valid, "R3 older without address blocks", mreq_valid, 0);
    agen(4, 32'h40, 0);
    chk(mreq_valid && mreq_tag == 4, "R7 older offered first", mreq_tag, 4);
    accept_one();
    chk(mreq_valid && mreq_tag == 5, "R3 released after older leaves", mreq_tag, 5);
    drain();
  endtask

  task automatic t_store_alias();
    head_ptr = 7;
    enq(0, 1); enq(1, 0); enq(2, 0);
    agen(0, 32'h800, 32'h5555_AAAA); agen(1, 32'h800, 0); agen(2, 32'h900, 0);
    chk(mreq_valid && mreq_tag == 2, "R4 different address passes older store", mreq_tag, 2);
    accept_one();
    chk(!mreq_valid, "R4 same address blocked by older store / R6 store waits", mreq_valid, 0);
    head_ptr = 0; tick();
    chk(mreq_valid && mreq_tag == 0 && mreq_is_store && mreq_addr == 32'h800 &&
        mreq_wdata == 32'h5555_AAAA, "R6 store offered at head",
        {mreq_is_store, mreq_tag, mreq_wdata}, {1'b1, 3'd0, 32'h5555_AAAA});
    accept_one();
    chk(st_done_valid && st_done_slot == 0, "R10 store done next cycle",
        {st_done_valid, st_done_slot}, {1'b1, 3'd0});
    chk(mreq_valid && mreq_tag == 1 && !mreq_is_store, "R4 load freed after store leaves", mreq_tag, 1);
    accept_one();
    chk(!st_done_valid, "R10 single pulse", st_done_valid, 0);
    drain();
  endtask

  task automatic t_back_to_back();
    head_ptr = 0;
    enq(2, 0); enq(3, 0); agen(2, 32'h300, 0); agen(3, 32'h300, 0);
    mreq_ready = 1; tick();            // n1, tag2 accepted
    chk(mreq_valid && mreq_tag == 3, "R5 second load offered next", mreq_tag, 3);
    tick(); mreq_ready = 0;            // n2, tag3 accepted
    tick();                            // n3
    mem_rdata = 32'h0000_2222;
    tick();                            // n4
    mem_rdata = 32'h0000_3333;
    chk(wb_valid && wb_slot == 2 && wb_data == 32'h2222, "R5 first return",
        {wb_valid, wb_slot, wb_data}, {1'b1, 3'd2, 32'h2222});
    tick();                            // n5
    mem_rdata = 32'hDEAD_BEEF;
    chk(wb_valid && wb_slot == 3 && wb_data == 32'h3333, "R5 second return",
        {wb_valid, wb_slot, wb_data}, {1'b1, 3'd3, 32'h3333});
    repeat (3) tick();
  endtask

  task automatic t_wrap_age();
    head_ptr = 6;
    enq(1, 0); enq(6, 0); agen(1, 32'h10, 0); agen(6, 32'h60, 0);
    chk(mreq_valid && mreq_tag == 6, "R7 head-relative age wins over index", mreq_tag, 6);
    accept_one();
    chk(mreq_valid && mreq_tag == 1, "R7 next oldest after wrap", mreq_tag, 1);
    drain();
    chk(!mreq_valid, "R11 table empty after dispatch", mreq_valid, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_single_load();
    t_no_addr_blocks();
    t_store_alias();
    t_back_to_back();
    t_wrap_age();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule